// File: doc/BRIEF.md
# Three-Way Fixed-Priority Resource Arbiter

This block hands one shared resource to one of three requesting devices at a time. Each device raises its own request line and receives its own grant line. The block is a clocked Moore machine. It has an idle state and one ownership state per device, kept in a 2-bit owner register: 00 means idle, 01 means device 1, 10 means device 2 and 11 means device 3. The grant lines are decoded from that register alone, so a grant appears one clock edge after its request is sampled.

When the block is idle and several devices request together, device 1 wins over device 2, and device 2 wins over device 3. Once a device owns the resource it keeps it for as long as its own request stays high. No other request, including one of higher priority, can take it away. When the owner drops its request, the block returns to idle for exactly one cycle with all grants low, and then it arbitrates again among the requests present at that time.

Bit `i` of `req` and `grant` belongs to device `i+1`, so bit 0 is device 1 and has the highest priority.

Top module: `prioArbiter`

## Requirements
- R1: A high `rst` at a rising clock edge puts the block in idle, so every bit of `grant` is 0 after that edge. Reset is active-high and synchronous.
- R2: At most one bit of `grant` is 1 in any cycle.
- R3: In idle, if `req[0]` is 1 at an edge, then after that edge `grant` is 3'b001, whatever `req[1]` and `req[2]` are.
- R4: In idle, if `req[0]` is 0 and `req[1]` is 1 at an edge, then after that edge `grant` is 3'b010, whatever `req[2]` is.
- R5: In idle, if `req` is 3'b100 at an edge, then after that edge `grant` is 3'b100.
- R6: In idle, if `req` is 3'b000 at an edge, the block stays idle and `grant` remains 3'b000.
- R7: While `grant[i]` is 1 and `req[i]` stays 1, `grant` does not change after the edge. The other request bits have no effect on it.
- R8: If `grant[i]` is 1 and `req[i]` is 0 at an edge, `grant` becomes 3'b000 after that edge, even when other requests are pending.
- R9: After the one idle cycle that follows a release, the next edge grants the highest-priority request present at that edge. That request may come from the device that just released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state changes only on its rising edge |
| rst | input | 1 | Active-high synchronous reset to idle |
| req | input | 3 | Request lines; bit 0 is device 1 (highest priority), bit 2 is device 3 |
| grant | output | 3 | Grant lines decoded from state; same bit order as `req` |

## Verification
The properties treat an all-zero `grant` as the idle state. This holds because only the owner code 00 decodes to no grant. The properties also assume that `req` is stable around each rising edge. The bench keeps to that assumption by changing `req` only on falling edges and sampling `grant` on the following falling edge.

The bench walks through ownership, hold, release and re-arbitration sequences, including higher-priority requests that arrive while another device owns the resource. It then resets into idle before each of the eight request patterns, so that every priority choice is taken from a clean idle state.

// File: rtl/arb_pkg.sv
package arb_pkg;
  parameter int ARB_REQS = 3;
  localparam int OWNER_W = $clog2(ARB_REQS + 1);

  typedef logic [OWNER_W-1:0] owner_t;
  localparam owner_t OWNER_IDLE = '0;

  // strobes from control to the owner datapath
  typedef struct packed {
    logic   dropOwner;  // current owner released: return to idle
    logic   grantNew;   // idle and a winner was chosen
    owner_t winner;     // owner code to load when grantNew
  } arbStrobe_t;
endpackage

// File: rtl/arbControl.sv
module arbControl
  import arb_pkg::*;
(
  input  logic [ARB_REQS-1:0] reqLines,
  input  logic [ARB_REQS-1:0] grantVec,
  output arbStrobe_t          strobe
);
  logic isIdle;
  logic ownerStillWants;

  assign isIdle          = (grantVec == '0);
  assign ownerStillWants = |(reqLines & grantVec);

  always_comb begin
    strobe = '0;
    if (isIdle) begin
      // scan from lowest priority up so the highest priority wins
      for (int i = ARB_REQS - 1; i >= 0; i--) begin
        if (reqLines[i]) begin
          strobe.grantNew = 1'b1;
          strobe.winner   = owner_t'(i + 1);
        end
      end
    end else begin
      strobe.dropOwner = !ownerStillWants;
    end
  end
endmodule

// File: rtl/arbOwnerPath.sv
module arbOwnerPath
  import arb_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  arbStrobe_t          strobe,
  output logic [ARB_REQS-1:0] grantVec
);
  owner_t ownerQ;

  always_ff @(posedge clk) begin
    if (rst)                   ownerQ <= OWNER_IDLE;
    else if (strobe.dropOwner) ownerQ <= OWNER_IDLE;
    else if (strobe.grantNew)  ownerQ <= strobe.winner;
  end

  for (genvar g = 0; g < ARB_REQS; g++) begin : gDecode
    assign grantVec[g] = (ownerQ == owner_t'(g + 1));
  end
endmodule

// File: rtl/prioArbiter.sv
module prioArbiter
  import arb_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [ARB_REQS-1:0] req,
  output logic [ARB_REQS-1:0] grant
);
  arbStrobe_t strobe;
  logic [ARB_REQS-1:0] grantVec;

  arbControl uCtrl (
    .reqLines (req),
    .grantVec (grantVec),
    .strobe   (strobe)
  );

  arbOwnerPath uPath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .grantVec (grantVec)
  );

  assign grant = grantVec;
endmodule

// File: rtl/prioArbiterChecker.sv
module prioArbiterChecker
  import arb_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic [ARB_REQS-1:0] req,
  input logic [ARB_REQS-1:0] grant
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (grant == '0));

  assert_single_grant_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  assert_pick_first_R3: assert property (@(posedge clk) disable iff (rst)
    (grant == '0 && req[0]) |=> (grant == 3'b001));

  assert_pick_second_R4: assert property (@(posedge clk) disable iff (rst)
    (grant == '0 && !req[0] && req[1]) |=> (grant == 3'b010));

  assert_pick_third_R5: assert property (@(posedge clk) disable iff (rst)
    (grant == '0 && req == 3'b100) |=> (grant == 3'b100));

  assert_stay_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (grant == '0 && req == '0) |=> (grant == '0));

  for (genvar i = 0; i < ARB_REQS; i++) begin : gOwner
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (grant[i] && req[i]) |=> $stable(grant));

    assert_release_R8: assert property (@(posedge clk) disable iff (rst)
      (grant[i] && !req[i]) |=> (grant == '0));
  end
endmodule

bind prioArbiter prioArbiterChecker uChk (
  .clk   (clk),
  .rst   (rst),
  .req   (req),
  .grant (grant)
);

// File: tb/test_prioArbiter.sv
module test_prioArbiter;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 13;
  // {req, grant expected after the next edge}; starts from idle
  localparam logic [5:0] VEC [NVEC] = '{
    {3'b000, 3'b000},  // R6 idle stays
    {3'b111, 3'b001},  // R3 device 1 wins
    {3'b111, 3'b001},  // R7 hold
    {3'b110, 3'b000},  // R8 release with pending
    {3'b110, 3'b010},  // R4 R9 re-arbitrate
    {3'b011, 3'b010},  // R7 higher request ignored
    {3'b001, 3'b000},  // R8 release
    {3'b100, 3'b100},  // R5 device 3 alone
    {3'b111, 3'b100},  // R7 no preemption
    {3'b011, 3'b000},  // R8 release
    {3'b011, 3'b001},  // R9 fresh choice
    {3'b000, 3'b000},  // R8 release
    {3'b000, 3'b000}   // R6 idle stays
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] req = '0;
  logic [2:0] grant;
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  prioArbiter i_prioArbiter (
    .clk   (clk),
    .rst   (rst),
    .req   (req),
    .grant (grant)
  );

  function automatic logic [2:0] prioOf(input logic [2:0] r);
    if (r[0])      return 3'b001;
    else if (r[1]) return 3'b010;
    else if (r[2]) return 3'b100;
    return 3'b000;
  endfunction

  task automatic checkGrant(input logic [2:0] exp, input string tag);
    checks++;
    if (grant !== exp) begin
      errors++;
      $display("FAIL %s: grant=%b expected=%b", tag, grant, exp);
    end
    checks++;
    if ($countones(grant) > 1) begin
      errors++;
      $display("FAIL R2: grant=%b expected at most one bit set", grant);
    end
  endtask

  task automatic stepTo(input logic [2:0] r);
    req = r;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    req = '0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(posedge clk);
    @(negedge clk);
    checkGrant(3'b000, "R1 reset state");
    rst = 1'b0;

    for (int k = 0; k < NVEC; k++) begin
      stepTo(VEC[k][5:3]);
      checkGrant(VEC[k][2:0], $sformatf("R3-R9 vector %0d", k));
    end

    // priority from idle for all eight patterns (R3 R4 R5 R6)
    for (int p = 0; p < 8; p++) begin
      doReset();
      stepTo(3'(p));
      checkGrant(prioOf(3'(p)), $sformatf("R3 R4 R5 R6 pattern %0d", p));
    end

    // R1 reset while a device owns the resource
    doReset();
    stepTo(3'b010);
    checkGrant(3'b010, "R4 before reset");
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    checkGrant(3'b000, "R1 reset during grant");
    rst = 1'b0;

    // R7 long hold of device 3 against every other request
    stepTo(3'b100);
    for (int j = 0; j < 4; j++) begin
      stepTo({1'b1, 2'(j)});
      checkGrant(3'b100, "R7 long hold");
    end
    // R8 then R9: the releasing device can win again
    stepTo(3'b011);
    checkGrant(3'b000, "R8 idle gap");
    stepTo(3'b100);
    checkGrant(3'b100, "R9 same device regains");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule